// File: doc/BRIEF.md
# CAS-Before-RAS Refresh Sequencer

This block keeps an asynchronous DRAM alive by issuing CAS-before-RAS refresh cycles. In such a cycle the column strobe is pulled low ahead of the row strobe, so the DRAM takes the row from its own internal counter and no refresh address has to be driven. A free-running interval timer, compared against a programmable value, marks each refresh event. The event stays pending until it is served.

A pending event moves the sequencer out of `IDLE` into `ASK`, where it raises a bus request to the access controller and waits for the grant. Once granted, it runs a batch of 4096 refresh cycles back to back, counted as 16 groups of 256. Each cycle walks through four states:

- `CAS_LEAD`: CAS low, RAS high.
- `BOTH_LOW`: both strobes low.
- `RAS_TAIL`: CAS back high, RAS still low.
- `PRECHARGE`: both strobes high.

Every state holds for its own parameterised number of clocks. After the precharge of the last cycle the sequencer spends one clock in `FINISH`, which pulses `done`, and then returns to `IDLE`. Entering `IDLE` drops the bus request.

The state transitions are:

- `IDLE`→`ASK` on a pending event.
- `ASK`→`CAS_LEAD` on grant.
- `CAS_LEAD`→`BOTH_LOW`→`RAS_TAIL`→`PRECHARGE`, each taken when its dwell time expires.
- `PRECHARGE`→`CAS_LEAD` when more cycles remain.
- `PRECHARGE`→`FINISH` after the last cycle.
- `FINISH`→`IDLE` unconditionally.

Top module: `cbr_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n` and `cas_n` are 1 and `bus_req` and `done` are 0.
- R2: With the timer enabled from a cleared state and compare value N, `bus_req` rises on the (N+2)th rising clock edge after enable is first sampled high.
- R3: While `bus_req` is high and `bus_gnt` is low, `bus_req` stays high and both strobes stay at 1.
- R4: On the first edge that samples `bus_gnt` high in `ASK`, `cas_n` falls. `ras_n` falls exactly T_CSR clocks after `cas_n` falls, and never while `cas_n` is 1.
- R5: `cas_n` rises T_CHR clocks after `ras_n` fell, while `ras_n` is still 0. `ras_n` rises T_RASH clocks after that, with `cas_n` at 1. Both then stay high for T_RP clocks before the next `cas_n` fall.
- R6: One granted batch contains exactly GROUPS×GROUP_LEN (default 4096) falling edges of each strobe.
- R7: `done` is high for exactly one clock, starting T_RP clocks after the last `ras_n` rise. `bus_req` is 0 on the clock after `done`.
- R8: A strobe is low only while both `bus_req` and `bus_gnt` are high.
- R9: Timer events that arrive during a batch merge into a single pending request. Exactly one more batch follows, and `bus_req` is low for exactly one clock between the two batches.
- R10: While the timer is disabled its counter is cleared and no new request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_en | input | 1 | Interval timer enable |
| interval | input | IV_W | Timer compare value N; the period is N+1 clocks |
| bus_gnt | input | 1 | Grant from the access controller |
| bus_req | output | 1 | Request for the DRAM strobes, held through the batch |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| done | output | 1 | One-clock pulse at the end of a batch |

## Verification
The bench changes inputs and samples outputs on falling clock edges.

- **Outputs:** all outputs are flops decoded from the next state, so each one moves on the same rising edge as the state change that causes it.
- **Request latency:** `bus_req` is therefore expected exactly N+2 samples after enable, and the first CAS fall on the first sample that shows the grant.
- **Strobe monitor:** a monitor timestamps every strobe edge and compares the gap to the previous edge against T_CSR, T_CHR, T_RASH or T_RP. It also checks that the `done` rise follows the last RAS rise by T_RP samples.
- **Batch boundary:** after `done` is observed, the bench samples `bus_req` one and two clocks later to check the release and the single idle gap.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ASK       = 3'd1,
        ST_CAS_LEAD  = 3'd2,
        ST_BOTH_LOW  = 3'd3,
        ST_RAS_TAIL  = 3'd4,
        ST_PRECHARGE = 3'd5,
        ST_FINISH    = 3'd6
    } cbr_state_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
    parameter int IV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmr_en,
    input  logic [IV_W-1:0] interval,
    input  logic            ack,
    output logic            pending
);
    logic [IV_W-1:0] cnt_q;
    logic            hit;
    logic            pend_q;

    assign hit = tmr_en && (cnt_q >= interval);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!tmr_en) begin
            cnt_q <= '0;
        end else if (hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // a fresh event in the acknowledge cycle stays pending
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= hit | (pend_q & ~ack);
        end
    end

    assign pending = pend_q;

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack) |=> pend_q);

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_en && !pend_q) |=> !pend_q);

endmodule

// File: rtl/cbr_batch_counter.sv
module cbr_batch_counter #(
    parameter int GROUPS    = 16,
    parameter int GROUP_LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CYC_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;

    logic [CYC_W-1:0] cyc_q;
    logic             cyc_last;
    logic             grp_last;

    assign cyc_last = (cyc_q == CYC_W'(GROUP_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (clear) begin
            cyc_q <= '0;
        end else if (step) begin
            cyc_q <= cyc_last ? '0 : cyc_q + 1'b1;
        end
    end

    generate
        if (GROUPS > 1) begin : g_grouped
            localparam int GRP_W = $clog2(GROUPS);
            logic [GRP_W-1:0] grp_q;

            assign grp_last = (grp_q == GRP_W'(GROUPS - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    grp_q <= '0;
                end else if (clear) begin
                    grp_q <= '0;
                end else if (step && cyc_last) begin
                    grp_q <= grp_q + 1'b1;
                end
            end
        end else begin : g_single
            assign grp_last = 1'b1;
        end
    endgenerate

    assign last = cyc_last && grp_last;

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !last);

endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
    import cbr_pkg::*;
#(
    parameter int T_CSR  = 1,
    parameter int T_CHR  = 2,
    parameter int T_RASH = 2,
    parameter int T_RP   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic bus_gnt,
    input  logic last,
    output logic ack,
    output logic cnt_clear,
    output logic cnt_step,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int TMAX = max4(T_CSR, T_CHR, T_RASH, T_RP);
    localparam int DW_W = $clog2(TMAX) + 1;

    cbr_state_e       state_q, state_d;
    logic [DW_W-1:0]  dwell_q;
    logic [DW_W-1:0]  dwell_load;
    logic             dwell_end;

    assign dwell_end = (dwell_q == '0);

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (pending)   state_d = ST_ASK;
            ST_ASK:       if (bus_gnt)   state_d = ST_CAS_LEAD;
            ST_CAS_LEAD:  if (dwell_end) state_d = ST_BOTH_LOW;
            ST_BOTH_LOW:  if (dwell_end) state_d = ST_RAS_TAIL;
            ST_RAS_TAIL:  if (dwell_end) state_d = ST_PRECHARGE;
            ST_PRECHARGE: if (dwell_end) state_d = last ? ST_FINISH : ST_CAS_LEAD;
            ST_FINISH:                   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_d)
            ST_CAS_LEAD:  dwell_load = DW_W'(T_CSR - 1);
            ST_BOTH_LOW:  dwell_load = DW_W'(T_CHR - 1);
            ST_RAS_TAIL:  dwell_load = DW_W'(T_RASH - 1);
            ST_PRECHARGE: dwell_load = DW_W'(T_RP - 1);
            default:      dwell_load = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // dwell timer: reloads on every state change, counts down otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dwell_q <= '0;
        end else if (state_d != state_q) begin
            dwell_q <= dwell_load;
        end else if (!dwell_end) begin
            dwell_q <= dwell_q - 1'b1;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_req <= 1'b0;
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            done    <= 1'b0;
        end else begin
            bus_req <= (state_d != ST_IDLE);
            cas_n   <= !((state_d == ST_CAS_LEAD) || (state_d == ST_BOTH_LOW));
            ras_n   <= !((state_d == ST_BOTH_LOW) || (state_d == ST_RAS_TAIL));
            done    <= (state_d == ST_FINISH);
        end
    end

    assign ack       = (state_q == ST_ASK) && bus_gnt;
    assign cnt_clear = ack;
    assign cnt_step  = (state_q == ST_PRECHARGE) && dwell_end && !last;

    // R4
    cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n);

    // R5
    cas_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> !ras_n);

    // R5
    ras_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> cas_n);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !bus_req));

    // R3
    ask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASK && !bus_gnt) |=> (bus_req && ras_n && cas_n));

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
    parameter int IV_W      = 16,
    parameter int GROUPS    = 16,
    parameter int GROUP_LEN = 256,
    parameter int T_CSR     = 1,
    parameter int T_CHR     = 2,
    parameter int T_RASH    = 2,
    parameter int T_RP      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tmr_en,
    input  logic [IV_W-1:0] interval,
    input  logic            bus_gnt,
    output logic            bus_req,
    output logic            ras_n,
    output logic            cas_n,
    output logic            done
);
    logic pending;
    logic ack;
    logic cnt_clear;
    logic cnt_step;
    logic last;

    cbr_interval_timer #(.IV_W(IV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_en   (tmr_en),
        .interval (interval),
        .ack      (ack),
        .pending  (pending)
    );

    cbr_batch_counter #(.GROUPS(GROUPS), .GROUP_LEN(GROUP_LEN)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .step  (cnt_step),
        .last  (last)
    );

    cbr_strobe_fsm #(
        .T_CSR  (T_CSR),
        .T_CHR  (T_CHR),
        .T_RASH (T_RASH),
        .T_RP   (T_RP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .bus_gnt   (bus_gnt),
        .last      (last),
        .ack       (ack),
        .cnt_clear (cnt_clear),
        .cnt_step  (cnt_step),
        .bus_req   (bus_req),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .done      (done)
    );

    // R8
    strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> (bus_gnt && bus_req));

endmodule

// File: tb/cbr_refresh_seq_bench.sv
module cbr_refresh_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_CSR  = 1;
    localparam int T_CHR  = 2;
    localparam int T_RASH = 2;
    localparam int T_RP   = 2;
    localparam int NCYC   = 16 * 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0;
    logic [15:0] interval = '0;
    logic        bus_gnt = 1'b0;
    logic        auto_gnt = 1'b0;
    logic        bus_req, ras_n, cas_n, done;

    int checks = 0;
    int failures = 0;

    // monitor state
    int cyc = 0;
    int cas_falls = 0, ras_falls = 0, done_cnt = 0;
    int err_r4 = 0, err_r5 = 0, err_r7 = 0, err_r8 = 0;
    int t_cf = 0, t_rf = 0, t_cr = 0, t_rr = 0;
    bit first_in_batch = 1'b1;
    logic p_ras = 1'b1, p_cas = 1'b1, p_done = 1'b0, p_gnt = 1'b0;

    cbr_refresh_seq u_cbr_refresh_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_en   (tmr_en),
        .interval (interval),
        .bus_gnt  (bus_gnt),
        .bus_req  (bus_req),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .done     (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // access controller model: grants while requested and permitted
    always @(negedge clk) bus_gnt <= auto_gnt && bus_req;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cas && !cas_n) begin
                cas_falls++;
                if (!ras_n) err_r4++;
                if (!first_in_batch && (cyc - t_rr != T_RP)) err_r5++;
                first_in_batch = 1'b0;
                t_cf = cyc;
            end
            if (p_ras && !ras_n) begin
                ras_falls++;
                if (cas_n || (cyc - t_cf != T_CSR)) err_r4++;
                t_rf = cyc;
            end
            if (!p_cas && cas_n) begin
                if (ras_n || (cyc - t_rf != T_CHR)) err_r5++;
                t_cr = cyc;
            end
            if (!p_ras && ras_n) begin
                if (!cas_n || (cyc - t_cr != T_RASH)) err_r5++;
                t_rr = cyc;
            end
            if (done && !p_done) begin
                done_cnt++;
                if (cyc - t_rr != T_RP) err_r7++;
                first_in_batch = 1'b1;
            end
            if (done && p_done) err_r7++;
            if (!done && p_done && bus_req) err_r7++;
            if (bus_gnt && !p_gnt && cas_n) err_r4++;
            if ((!ras_n || !cas_n) && !(bus_gnt && bus_req)) err_r8++;
        end
        p_ras = ras_n; p_cas = cas_n; p_done = done; p_gnt = bus_gnt;
        cyc++;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done(input string req, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        check_eq(req, "done seen before timeout", int'(ok), 1);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check_eq("R1", "ras_n in reset", int'(ras_n), 1);
        check_eq("R1", "cas_n in reset", int'(cas_n), 1);
        check_eq("R1", "bus_req in reset", int'(bus_req), 0);
        check_eq("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
    endtask

    task automatic test_timer_off();
        int seen = 0;
        interval = 16'd3;
        tmr_en = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (bus_req) seen++;
        end
        check_eq("R10", "request samples with timer off", seen, 0);
    endtask

    task automatic test_first_request();
        int k = 0;
        @(negedge clk);
        interval = 16'd20;
        tmr_en = 1'b1;
        do begin
            @(negedge clk);
            k++;
        end while (!bus_req && k < 100);
        tmr_en = 1'b0;
        check_eq("R2", "clocks from enable to request", k, 22);
    endtask

    task automatic test_grant_hold();
        int drops = 0, strobes = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!bus_req) drops++;
            if (!ras_n || !cas_n) strobes++;
        end
        check_eq("R3", "request drops without grant", drops, 0);
        check_eq("R3", "strobe activity without grant", strobes, 0);
    endtask

    task automatic test_batch();
        int c0 = cas_falls, r0 = ras_falls, d0 = done_cnt;
        int e4 = err_r4, e5 = err_r5, e7 = err_r7, e8 = err_r8;
        bit ok;
        auto_gnt = 1'b1;
        wait_done("R7", ok);
        @(negedge clk);
        check_eq("R7", "bus_req after done", int'(bus_req), 0);
        repeat (4) @(negedge clk);
        check_eq("R6", "cas falls in batch", cas_falls - c0, NCYC);
        check_eq("R6", "ras falls in batch", ras_falls - r0, NCYC);
        check_eq("R7", "done pulses", done_cnt - d0, 1);
        check_eq("R4", "cas-first order and grant timing errors", err_r4 - e4, 0);
        check_eq("R5", "cycle phase timing errors", err_r5 - e5, 0);
        check_eq("R7", "done timing errors", err_r7 - e7, 0);
        check_eq("R8", "strobe without grant", err_r8 - e8, 0);
    endtask

    task automatic test_coalesce();
        int c0 = cas_falls, d0 = done_cnt, e5 = err_r5, e8 = err_r8;
        bit ok;
        int late = 0;
        @(negedge clk);
        interval = 16'd40;
        tmr_en = 1'b1;
        wait_done("R9", ok);
        tmr_en = 1'b0;
        @(negedge clk);
        check_eq("R9", "bus_req one clock after first done", int'(bus_req), 0);
        @(negedge clk);
        check_eq("R9", "bus_req two clocks after first done", int'(bus_req), 1);
        wait_done("R9", ok);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (bus_req) late++;
        end
        check_eq("R9", "batches from merged events", done_cnt - d0, 2);
        check_eq("R9", "cas falls over two batches", cas_falls - c0, 2 * NCYC);
        check_eq("R10", "requests after timer disabled", late, 0);
        check_eq("R5", "phase timing errors", err_r5 - e5, 0);
        check_eq("R8", "strobe without grant", err_r8 - e8, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        failures++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        test_reset();
        test_timer_off();
        test_first_request();
        test_grant_hold();
        test_batch();
        test_coalesce();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule